// File: doc/BRIEF.md
# PDM Microphone to TDM Bridge

This block connects up to `2*PAIRS` pulse-density-modulated microphones to a serial TDM receiver. Each data line is shared by a left/right microphone pair. The block drives a bitstream clock to each pair and samples the shared line on both clock edges. It builds one byte per microphone per frame and shifts those bytes out on a single serial line, one 8-bit slot per microphone.

Once enabled, the block waits for one frame sync pulse from the TDM master and locks its frame timing to it. From then on it runs freely: a frame lasts eight bitstream clock periods and later sync pulses are ignored. Bytes captured in one frame go out in the next frame. The first two output frames after lock are flagged so that downstream logic can drop them. A valid indication rises once the first fully assembled frame starts to go out.

Top module: `pdm_tdm_bridge`

## Requirements
- R1: While `enable` is high and no frame sync has yet been seen, `mic_clk` is all zero, `tdm_sd` is 0 and both `data_valid` and `frame_bad` are low.
- R2: In the cycle after `enable` and `tdm_fs` are both high in the waiting state, frame cycle 0 begins. A frame is `16*PAIRS` clock cycles. Each bitstream clock period is `2*PAIRS` cycles: low for the first half and high for the second half.
- R3: Pair p's data line is sampled for the left microphone at the clock edge that ends the low half (the bitstream rising edge), and for the right microphone at the edge that ends the high half (the falling edge). The first bit captured in a frame becomes bit 7 of that microphone's byte.
- R4: Frame sync pulses that arrive while the block is running are ignored, and frame timing continues unchanged.
- R5: Bytes captured in frame N are sent in frame N+1. Slot s occupies frame cycles 8s to 8s+7 and carries microphone s, where microphone 2p is the left microphone of pair p and microphone 2p+1 is the right one.
- R6: Slots whose index is at least `mic_count` drive `tdm_sd` low for all eight cycles.
- R7: With `lsb_first` = 0 a slot sends bit 7 first and bit 0 last. With `lsb_first` = 1 it sends bit 0 first and bit 7 last.
- R8: `frame_bad` is high during output frames 0 and 1 after lock, and low afterwards.
- R9: `data_valid` is low during output frame 0 and rises at the start of frame 1. It stays high until `enable` is cleared.
- R10: In the cycle after `enable` is sampled low, the clocks stop, `tdm_sd`, `data_valid` and `frame_bad` are low, and the block waits for a new frame sync once it is enabled again.
- R11: Bit p of `mic_clk` toggles only when bit p of `pair_clk_en` is set, and is held low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, one TDM bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the bridge; clearing it returns the bridge to waiting for sync |
| mic_count | input | $clog2(2*PAIRS+1) | Number of active microphone slots |
| pair_clk_en | input | PAIRS | Per-pair bitstream clock enable |
| lsb_first | input | 1 | Selects bit 0 first within each slot |
| tdm_fs | input | 1 | Frame sync from the TDM master |
| mic_data | input | PAIRS | Shared data line of each microphone pair |
| mic_clk | output | PAIRS | Bitstream clock to each microphone pair |
| tdm_sd | output | 1 | Serial data to the TDM receiver |
| data_valid | output | 1 | High once assembled frames are being sent |
| frame_bad | output | 1 | Marks the two start-up frames to discard |

## Verification
The main path is tested with three patterns.

The first uses all eight microphones sent MSB-first, with a byte for every microphone and frame that differs from all the others. This catches a swapped slot, swapped left/right sampling, and a pipeline delay of zero or two frames.

The second uses three microphones sent LSB-first, with the clocks of alternate pairs switched off. This separates bit reversal from slot reordering, checks that unused slots stay silent, and checks that clocks are gated per pair.

The third sends a stray frame sync in the middle of a run and a disable/re-enable cycle. These show whether the bridge wrongly resynchronizes and whether it returns to waiting for sync.

// File: rtl/pdm_tdm_bridge.sv
module pdm_tdm_bridge #(
  parameter int PAIRS = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           enable,
  input  logic [$clog2(2*PAIRS+1)-1:0]   mic_count,
  input  logic [PAIRS-1:0]               pair_clk_en,
  input  logic                           lsb_first,
  input  logic                           tdm_fs,
  input  logic [PAIRS-1:0]               mic_data,
  output logic [PAIRS-1:0]               mic_clk,
  output logic                           tdm_sd,
  output logic                           data_valid,
  output logic                           frame_bad
);
  localparam int MICS  = 2 * PAIRS;
  localparam int PER   = 2 * PAIRS;
  localparam int FRAME = 8 * PER;
  localparam int CW    = $clog2(FRAME);
  localparam int PW    = $clog2(PER);
  localparam int SW    = CW - 3;

  logic          run;
  logic [CW-1:0] cnt;
  logic [1:0]    frm;
  logic [8*MICS-1:0] hold_flat;

  wire [PW-1:0] phase  = cnt[PW-1:0];
  wire          wrap   = run && (cnt == CW'(FRAME - 1));
  wire          take_l = run && (phase == PW'(PER/2 - 1));
  wire          take_r = run && (phase == PW'(PER - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
      frm <= '0;
    end else if (!enable) begin
      run <= 1'b0;
      cnt <= '0;
      frm <= '0;
    end else if (!run) begin
      if (tdm_fs) run <= 1'b1;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap && frm != 2'd2) frm <= frm + 1'b1;
    end
  end

  for (genvar m = 0; m < MICS; m++) begin : g_mic
    logic [7:0] cap, hold, nxt;
    wire take = (m % 2 == 0) ? take_l : take_r;
    assign nxt = take ? {cap[6:0], mic_data[m/2]} : cap;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cap  <= '0;
        hold <= '0;
      end else begin
        cap <= nxt;
        if (wrap) hold <= nxt;
      end
    end
    assign hold_flat[8*m +: 8] = hold;
  end

  wire [SW-1:0] slot = cnt[CW-1:3];
  wire [2:0]    bsel = lsb_first ? cnt[2:0] : ~cnt[2:0];

  assign tdm_sd     = run && ({1'b0, slot} < mic_count) && hold_flat[{slot, bsel}];
  assign mic_clk    = pair_clk_en & {PAIRS{run & cnt[PW-1]}};
  assign data_valid = run && (frm != 2'd0);
  assign frame_bad  = run && (frm != 2'd2);
endmodule

module pdm_tdm_bridge_chk #(
  parameter int PAIRS = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         enable,
  input logic [$clog2(2*PAIRS+1)-1:0] mic_count,
  input logic [PAIRS-1:0]             mic_clk,
  input logic                         tdm_sd,
  input logic                         data_valid,
  input logic                         frame_bad
);
  // R10
  stop_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (mic_clk == '0 && !tdm_sd && !data_valid && !frame_bad));

  // R9
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && enable) |=> data_valid);

  // R8
  bad_stays_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && !frame_bad) |=> !frame_bad);

  // R8
  first_valid_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> frame_bad);

  // R6
  no_mics_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mic_count == '0) |-> !tdm_sd);
endmodule

bind pdm_tdm_bridge pdm_tdm_bridge_chk #(.PAIRS(PAIRS)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .mic_count(mic_count),
  .mic_clk(mic_clk), .tdm_sd(tdm_sd), .data_valid(data_valid), .frame_bad(frame_bad)
);

// File: tb/pdm_tdm_bridge_tb.sv
`timescale 1ns/1ps
module pdm_tdm_bridge_tb;
  localparam int PAIRS = 4;
  localparam int MICS  = 2 * PAIRS;
  localparam int PER   = 2 * PAIRS;
  localparam int FRAME = 8 * PER;
  localparam int NW    = $clog2(MICS + 1);

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, lsb_first = 1'b0, tdm_fs = 1'b0;
  logic [NW-1:0]    mic_count = '0;
  logic [PAIRS-1:0] pair_clk_en = '0;
  logic [PAIRS-1:0] mic_data, mic_clk;
  logic tdm_sd, data_valid, frame_bad;

  int nvec = 0, nbad = 0;
  logic [7:0] act = '0;

  always #2.5 clk = ~clk;

  pdm_tdm_bridge #(.PAIRS(PAIRS)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mic_count(mic_count),
    .pair_clk_en(pair_clk_en), .lsb_first(lsb_first), .tdm_fs(tdm_fs),
    .mic_data(mic_data), .mic_clk(mic_clk), .tdm_sd(tdm_sd),
    .data_valid(data_valid), .frame_bad(frame_bad)
  );

  // frame timing model from R2/R4/R10
  logic brun = 1'b0;
  int bc = 0, bf = 0;
  always @(posedge clk) begin
    if (!enable) begin
      brun <= 1'b0; bc <= 0; bf <= 0;
    end else if (!brun) begin
      if (tdm_fs) brun <= 1'b1;
    end else if (bc == FRAME - 1) begin
      bc <= 0; bf <= bf + 1;
    end else begin
      bc <= bc + 1;
    end
  end

  function automatic logic [7:0] smp(int f, int m);
    return 8'((f * 37 + m * 53 + 11) & 255);
  endfunction

  // microphone model: left bit valid in low half, right bit in high half (R3)
  always_comb begin
    for (int p = 0; p < PAIRS; p++) begin
      logic [7:0] v;
      int k;
      k = bc / PER;
      v = ((bc % PER) < PER/2) ? smp(bf, 2*p) : smp(bf, 2*p + 1);
      mic_data[p] = brun ? v[7 - k] : 1'b0;
    end
  end

  task automatic chk(bit ok, string what, int a, int e);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: got %0h expected %0h", what, a, e);
    end
  endtask

  task automatic watch(int n, int fs_at);
    for (int i = 0; i < n; i++) begin
      logic [PAIRS-1:0] eclk;
      @(negedge clk);
      eclk = (brun && (bc % PER) >= PER/2) ? pair_clk_en : '0;
      chk(mic_clk == eclk, "R2 R11 microphone clock", mic_clk, eclk);
      chk(data_valid == (brun && bf >= 1), "R9 data_valid", data_valid, brun && bf >= 1);
      chk(frame_bad == (brun && bf < 2), "R8 frame_bad", frame_bad, brun && bf < 2);
      if (!brun) begin
        chk(tdm_sd == 1'b0, "R1 R10 idle serial output", tdm_sd, 0);
      end else begin
        int s, b;
        s = bc / 8; b = bc % 8;
        act[lsb_first ? b : 7 - b] = tdm_sd;
        if (b == 7) begin
          if (s >= int'(mic_count))
            chk(act == 8'h00, "R6 unused slot", act, 0);
          else if (bf >= 1)
            chk(act == smp(bf - 1, s), "R3 R5 R7 slot byte", act, smp(bf - 1, s));
        end
      end
      tdm_fs = (i == fs_at);
    end
    tdm_fs = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(mic_clk == '0 && !tdm_sd && !data_valid && !frame_bad, "R1 reset state",
        {mic_clk, tdm_sd, data_valid, frame_bad}, 0);
  endtask

  task automatic t_wait_sync;
    mic_count = NW'(MICS); pair_clk_en = '1; lsb_first = 1'b0;
    enable = 1'b1;
    watch(50, -1);
    chk(mic_clk == '0 && !data_valid, "R1 no clock before frame sync", mic_clk, 0);
  endtask

  task automatic t_all_mics_msb;
    watch(5 * FRAME + 3, 0);
  endtask

  // R4: stray sync in mid frame must not realign
  task automatic t_no_resync;
    watch(3 * FRAME, 100);
    watch(2 * FRAME, FRAME + 17);
  endtask

  task automatic t_config_lsb;
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(mic_clk == '0 && !tdm_sd && !data_valid && !frame_bad, "R10 stop after disable",
        {mic_clk, tdm_sd, data_valid, frame_bad}, 0);
    mic_count = NW'(3); lsb_first = 1'b1; pair_clk_en = 4'b0101;
    enable = 1'b1;
    watch(5 * FRAME + 40, 30);
  endtask

  task automatic t_disable;
    enable = 1'b0;
    watch(6, -1);
    enable = 1'b1;
    watch(40, -1);
    chk(!data_valid && mic_clk == '0, "R10 waits for new sync after re-enable", data_valid, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_wait_sync();
    t_all_mics_msb();
    t_no_resync();
    t_config_lsb();
    t_disable();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog (all requirements): got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule